// File: doc/BRIEF.md
# Interleaved ECC Memory Scrubber

This block keeps a small on-chip SRAM array healthy while it sits in an environment where particle strikes flip stored bits. Every 16-bit word is kept as a 22-bit single-error-correcting, double-error-detecting codeword. A background sequencer visits the words one after another and never stops. At each visit it reads the codeword, decodes it, and, if exactly one bit has flipped, writes the repaired codeword back. The aim is to clear latent single errors before a second strike can land in the same word.

A host port shares the array. Host requests always win arbitration. A scrub visit that has begun (one read cycle plus one write-back cycle) runs to the end, so the host is held off for at most two cycles. Host reads return corrected data but leave the stored bits untouched. Codewords of four consecutive addresses are woven bit by bit into one physical row, so a strike across a few neighbouring cells costs each word at most one bit.

Two saturating counters record the corrected and the uncorrectable words found by the sweep, and an interrupt pulses each time the sweep finds either. An upset input XORs a mask into a physical row. This models a strike.

Top module: `ecc_scrubber`

## Requirements
- R1: While rstN is low, both counters read 0, irq and hostRvalid are 0 and hostReady is 1.
- R2: A host access is taken at a rising edge where hostReq and hostReady are both 1. A read returns the last data written to that address on hostRdata, with hostRvalid high for exactly the cycle after it is taken.
- R3: A codeword is 22 bits. Bit 0 is the overall parity. Bits 1, 2, 4, 8 and 16 are the Hamming check bits. The 16 data bits fill the remaining positions 3..21 in ascending order. A single flipped bit anywhere in a word, including the overall parity bit, is corrected in the data a host read returns.
- R4: Codeword bit j of address a is stored in physical row a>>2 at column 4*j + a[1:0]. A pulse on upsetEn XORs upsetMask into row upsetRow at that edge. A strike over four adjacent columns of one row is corrected in all four words.
- R5: A host read never writes a correction back. A single error that the host has read is still found and counted by the sweep later.
- R6: With no host traffic, the sweep handles one address every scrubGap+3 cycles. It visits addresses in ascending order and wraps from the last to 0, so a given word is seen every 16*(scrubGap+3) cycles. A single error is repaired in the array and adds 1 to corrCount once.
- R7: A double error adds 1 to uncorrCount on every visit, is not written back and is never counted as corrected. A later host write to that word clears it.
- R8: hostReady is low only during the read and write-back cycles of a scrub visit, never for more than 2 cycles in a row. A visit does not start in a cycle where hostReq or upsetEn is high.
- R9: irq is a one-cycle pulse, raised at the same edge at which either counter increments.
- R10: Each counter stops at 2^CNT_W-1 and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostReq | input | 1 | Host access request |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Host word address |
| hostWdata | input | 16 | Host write data |
| hostReady | output | 1 | Host access can be taken this cycle |
| hostRdata | output | 16 | Corrected read data |
| hostRvalid | output | 1 | hostRdata valid |
| scrubGap | input | GAP_W | Idle cycles added between scrub visits |
| upsetEn | input | 1 | Apply upsetMask this cycle |
| upsetRow | input | ADDR_W-LANE_W | Physical row to disturb |
| upsetMask | input | 22*2^LANE_W | Bits to flip in that row |
| corrCount | output | CNT_W | Corrected words found by the sweep |
| uncorrCount | output | CNT_W | Uncorrectable words found by the sweep |
| irq | output | 1 | Pulse when the sweep finds an error |

## Verification
The hardest case to set up is the host and the sweep both touching a corrupted word. A host read of that word must return repaired data and still leave the fault for the sweep to count. The stimulus flips one cell through the upset port and reads the word at once, while a long scrub gap keeps the sweep away. It then waits for corrCount to move. Host stalls are forced by shrinking the gap to zero and leaving one idle cycle between reads, so every read lands on a scrub visit in progress. The sweep period and the wrap-around are measured from the spacing of the increments caused by a persistent double error.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;
  localparam int DATA_W = 16;
  localparam int HAM_N  = 21;
  localparam int PAR_N  = 5;
  localparam int CODE_W = HAM_N + 1;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    data_t data;
    logic  corr;
    logic  uncorr;
    code_t fixed;
  } dec_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic hostGo;
    logic hostWr;
    logic scrubRd;
    logic scrubWb;
  } strobe_t;

  function automatic logic isCheckPos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic code_t eccEncode(data_t d);
    code_t c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= HAM_N; p++) begin
      if (!isCheckPos(p)) begin
        c[p] = d[k];
        k++;
      end
    end
    for (int b = 0; b < PAR_N; b++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p <= HAM_N; p++) begin
        if (((p >> b) & 1) == 1 && p != (1 << b)) x ^= c[p];
      end
      c[1 << b] = x;
    end
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic dec_t eccDecode(code_t c);
    dec_t r;
    logic [PAR_N-1:0] syn;
    logic ovr;
    int k;
    syn = '0;
    for (int b = 0; b < PAR_N; b++) begin
      for (int p = 1; p <= HAM_N; p++) begin
        if (((p >> b) & 1) == 1) syn[b] ^= c[p];
      end
    end
    ovr = ^c;
    r.fixed  = c;
    r.corr   = 1'b0;
    r.uncorr = 1'b0;
    if (ovr) begin
      if (int'(syn) <= HAM_N) begin
        r.fixed[syn] = ~r.fixed[syn];
        r.corr = 1'b1;
      end else begin
        r.uncorr = 1'b1;
      end
    end else if (syn != '0) begin
      r.uncorr = 1'b1;
    end
    r.data = '0;
    k = 0;
    for (int p = 1; p <= HAM_N; p++) begin
      if (!isCheckPos(p)) begin
        r.data[k] = r.fixed[p];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_scrub_ctrl.sv
module ecc_scrub_ctrl
  import ecc_scrub_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic              upsetEn,
  input  logic [GAP_W-1:0]  scrubGap,
  output logic              hostReady,
  output strobe_t           strobe,
  output logic [ADDR_W-1:0] scrubAddr
);
  typedef enum logic [1:0] {S_WAIT, S_READ, S_WB} state_t;

  state_t           state;
  logic [GAP_W-1:0] gapCnt;
  logic             startScrub;

  assign hostReady  = (state == S_WAIT);
  // host and strike injection both defer the start of a visit
  assign startScrub = hostReady && (gapCnt >= scrubGap) && !hostReq && !upsetEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_WAIT;
      gapCnt    <= '0;
      scrubAddr <= '0;
    end else begin
      case (state)
        S_WAIT: begin
          if (startScrub)             state  <= S_READ;
          else if (gapCnt < scrubGap) gapCnt <= gapCnt + 1'b1;
        end
        S_READ: state <= S_WB;
        S_WB: begin
          state     <= S_WAIT;
          gapCnt    <= '0;
          scrubAddr <= scrubAddr + 1'b1;
        end
        default: state <= S_WAIT;
      endcase
    end
  end

  always_comb begin
    strobe.hostGo  = hostReq && hostReady;
    strobe.hostWr  = hostReq && hostReady && hostWe;
    strobe.scrubRd = (state == S_READ);
    strobe.scrubWb = (state == S_WB);
  end
endmodule

// File: rtl/ecc_scrub_datapath.sv
module ecc_scrub_datapath
  import ecc_scrub_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 2,
  parameter int CNT_W  = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             strobe,
  input  logic [ADDR_W-1:0]                   hostAddr,
  input  logic [DATA_W-1:0]                   hostWdata,
  input  logic [ADDR_W-1:0]                   scrubAddr,
  input  logic                                upsetEn,
  input  logic [ADDR_W-LANE_W-1:0]            upsetRow,
  input  logic [CODE_W*(1<<LANE_W)-1:0]       upsetMask,
  output logic [DATA_W-1:0]                   hostRdata,
  output logic                                hostRvalid,
  output logic [CNT_W-1:0]                    corrCount,
  output logic [CNT_W-1:0]                    uncorrCount,
  output logic                                irq
);
  localparam int LANES = 1 << LANE_W;
  localparam int RA_W  = ADDR_W - LANE_W;
  localparam int ROWS  = 1 << RA_W;
  localparam int ROW_W = CODE_W * LANES;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef logic [ROW_W-1:0] row_t;

  row_t              mem     [ROWS];
  row_t              rowNext [ROWS];
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  code_t             rdCode, snapCode, wrCode;
  dec_t              rdDec, snapDec;
  logic              wrEn;
  row_t              wrRowNew;

  // neighbouring columns belong to neighbouring lanes (words)
  function automatic code_t pickWord(row_t row, logic [LANE_W-1:0] lane);
    code_t c;
    for (int j = 0; j < CODE_W; j++) c[j] = row[j*LANES + int'(lane)];
    return c;
  endfunction

  always_comb begin
    rdAddr   = strobe.scrubRd ? scrubAddr : hostAddr;
    rdCode   = pickWord(mem[rdAddr[ADDR_W-1:LANE_W]], rdAddr[LANE_W-1:0]);
    rdDec    = eccDecode(rdCode);
    snapDec  = eccDecode(snapCode);
    wrEn     = strobe.hostWr || (strobe.scrubWb && snapDec.corr);
    wrAddr   = strobe.hostWr ? hostAddr : scrubAddr;
    wrCode   = strobe.hostWr ? eccEncode(hostWdata) : snapDec.fixed;
    wrRowNew = mem[wrAddr[ADDR_W-1:LANE_W]];
    for (int j = 0; j < CODE_W; j++)
      wrRowNew[j*LANES + int'(wrAddr[LANE_W-1:0])] = wrCode[j];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic wrHit, upHit;
    assign wrHit      = wrEn && (wrAddr[ADDR_W-1:LANE_W] == RA_W'(r));
    assign upHit      = upsetEn && (upsetRow == RA_W'(r));
    assign rowNext[r] = (wrHit ? wrRowNew : mem[r]) ^ (upHit ? upsetMask : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) mem[r] <= rowNext[r];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdata   <= '0;
      hostRvalid  <= 1'b0;
      snapCode    <= '0;
      corrCount   <= '0;
      uncorrCount <= '0;
      irq         <= 1'b0;
    end else begin
      hostRvalid <= strobe.hostGo && !strobe.hostWr;
      if (strobe.hostGo && !strobe.hostWr) hostRdata <= rdDec.data;
      if (strobe.scrubRd) snapCode <= rdCode;
      irq <= strobe.scrubWb && (snapDec.corr || snapDec.uncorr);
      if (strobe.scrubWb && snapDec.corr && corrCount != CNT_MAX)
        corrCount <= corrCount + 1'b1;
      if (strobe.scrubWb && snapDec.uncorr && uncorrCount != CNT_MAX)
        uncorrCount <= uncorrCount + 1'b1;
    end
  end
endmodule

// File: rtl/ecc_scrubber.sv
module ecc_scrubber
  import ecc_scrub_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 2,
  parameter int CNT_W  = 8,
  parameter int GAP_W  = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          hostReq,
  input  logic                          hostWe,
  input  logic [ADDR_W-1:0]             hostAddr,
  input  logic [DATA_W-1:0]             hostWdata,
  output logic                          hostReady,
  output logic [DATA_W-1:0]             hostRdata,
  output logic                          hostRvalid,
  input  logic [GAP_W-1:0]              scrubGap,
  input  logic                          upsetEn,
  input  logic [ADDR_W-LANE_W-1:0]      upsetRow,
  input  logic [CODE_W*(1<<LANE_W)-1:0] upsetMask,
  output logic [CNT_W-1:0]              corrCount,
  output logic [CNT_W-1:0]              uncorrCount,
  output logic                          irq
);
  strobe_t           strobe;
  logic [ADDR_W-1:0] scrubAddr;

  ecc_scrub_ctrl #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .upsetEn(upsetEn), .scrubGap(scrubGap), .hostReady(hostReady),
    .strobe(strobe), .scrubAddr(scrubAddr)
  );

  ecc_scrub_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .scrubAddr(scrubAddr), .upsetEn(upsetEn),
    .upsetRow(upsetRow), .upsetMask(upsetMask), .hostRdata(hostRdata),
    .hostRvalid(hostRvalid), .corrCount(corrCount),
    .uncorrCount(uncorrCount), .irq(irq)
  );
endmodule

// File: rtl/ecc_scrubber_sva.sv
module ecc_scrubber_sva #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostReq,
  input logic             hostWe,
  input logic             hostReady,
  input logic             hostRvalid,
  input logic [CNT_W-1:0] corrCount,
  input logic [CNT_W-1:0] uncorrCount,
  input logic             irq
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    hostRvalid |-> $past(hostReq && hostReady && !hostWe)); // R2

  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (!hostReady && $past(!hostReady)) |=> hostReady); // R8

  AST_CORR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (corrCount == $past(corrCount)) || (corrCount == $past(corrCount) + 1'b1)); // R6

  AST_UNCORR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (uncorrCount == $past(uncorrCount)) || (uncorrCount == $past(uncorrCount) + 1'b1)); // R7

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R9

  AST_IRQ_ON_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (corrCount != $past(corrCount) || uncorrCount != $past(uncorrCount)) |-> irq); // R9

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(uncorrCount) == TOP) |-> (uncorrCount == TOP)); // R10
endmodule

bind ecc_scrubber ecc_scrubber_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
  .hostReady(hostReady), .hostRvalid(hostRvalid), .corrCount(corrCount),
  .uncorrCount(uncorrCount), .irq(irq)
);

// File: tb/ecc_scrubber_bench.sv
module ecc_scrubber_bench;
  import ecc_scrub_pkg::*;
  localparam int ADDR_W = 4;
  localparam int LANE_W = 2;
  localparam int CNT_W  = 8;
  localparam int GAP_W  = 8;
  localparam int WORDS  = 1 << ADDR_W;
  localparam int RA_W   = ADDR_W - LANE_W;
  localparam int ROW_W  = CODE_W * (1 << LANE_W);

  logic clk = 1'b0;
  logic rstN;
  logic hostReq, hostWe, hostReady, hostRvalid, upsetEn, irq;
  logic [ADDR_W-1:0] hostAddr;
  logic [15:0] hostWdata, hostRdata;
  logic [GAP_W-1:0] scrubGap;
  logic [RA_W-1:0] upsetRow;
  logic [ROW_W-1:0] upsetMask;
  logic [CNT_W-1:0] corrCount, uncorrCount;

  ecc_scrubber u_ecc_scrubber (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostReady(hostReady),
    .hostRdata(hostRdata), .hostRvalid(hostRvalid), .scrubGap(scrubGap),
    .upsetEn(upsetEn), .upsetRow(upsetRow), .upsetMask(upsetMask),
    .corrCount(corrCount), .uncorrCount(uncorrCount), .irq(irq)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  int maxStall = 0;
  int irqPulses = 0;
  bit finished = 1'b0;
  logic [15:0] model [WORDS];
  logic [15:0] expQ [$];
  string tagQ [$];

  always @(posedge clk) cyc++;
  always @(negedge clk) if (rstN === 1'b1 && irq === 1'b1) irqPulses++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic [15:0] e;
    string t;
    if (rstN === 1'b1 && hostRvalid === 1'b1) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 unexpected read data", longint'(hostRdata), 0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(hostRdata == e, t, longint'(hostRdata), longint'(e));
      end
    end
  end

  // call at a falling edge
  task automatic hostOp(input bit we, input int a, input logic [15:0] d, input string tag);
    int stall;
    stall = 0;
    hostReq = 1'b1; hostWe = we; hostAddr = a[ADDR_W-1:0]; hostWdata = d;
    while (!hostReady) begin
      stall++;
      @(negedge clk);
    end
    if (stall > maxStall) maxStall = stall;
    if (we) model[a] = d;
    else begin
      expQ.push_back(model[a]);
      tagQ.push_back(tag);
    end
    @(negedge clk);
    hostReq = 1'b0;
  endtask

  task automatic strike(input int row, input logic [ROW_W-1:0] mask);
    while (!hostReady) @(negedge clk);
    upsetEn = 1'b1; upsetRow = row[RA_W-1:0]; upsetMask = mask;
    @(negedge clk);
    upsetEn = 1'b0; upsetMask = '0;
  endtask

  task automatic waitFor(input bit uncorr, input int tgt, input int limit);
    int n;
    n = 0;
    while (int'(uncorr ? uncorrCount : corrCount) != tgt && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int tA, tB, u0;
    rstN = 1'b0; hostReq = 1'b0; hostWe = 1'b0; hostAddr = '0; hostWdata = '0;
    scrubGap = 8'd20; upsetEn = 1'b0; upsetRow = '0; upsetMask = '0;
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(corrCount == 0,   "R1 corrCount",   longint'(corrCount), 0);
    chk(uncorrCount == 0, "R1 uncorrCount", longint'(uncorrCount), 0);
    chk(irq == 1'b0,      "R1 irq",         longint'(irq), 0);
    chk(hostRvalid == 1'b0, "R1 hostRvalid", longint'(hostRvalid), 0);
    chk(hostReady == 1'b1,  "R1 hostReady",  longint'(hostReady), 1);
    rstN = 1'b1;
    @(negedge clk);

    // R2 write / read every word
    for (int a = 0; a < WORDS; a++) hostOp(1'b1, a, 16'(a * 4381) ^ 16'hA55A, "R2");
    hostOp(1'b1, 3, 16'hFFFF, "R2");
    hostOp(1'b1, 4, 16'h0000, "R2");
    for (int a = 0; a < WORDS; a++) hostOp(1'b0, a, '0, "R2 readback");
    repeat (2) @(negedge clk);

    // R3 / R5 single flips: word 5 bit 7 (col 29), word 6 overall parity (col 2)
    strike(1, ROW_W'(1) << 29);
    hostOp(1'b0, 5, '0, "R3 corrected data bit");
    strike(1, ROW_W'(1) << 2);
    hostOp(1'b0, 6, '0, "R3 corrected parity bit");
    waitFor(1'b0, 2, 2000);
    chk(corrCount == 2, "R5 sweep still finds host-read errors", longint'(corrCount), 2);
    repeat (16 * 23 + 40) @(negedge clk);
    chk(corrCount == 2, "R6 repaired words not recounted", longint'(corrCount), 2);
    hostOp(1'b0, 5, '0, "R6 repaired word");
    hostOp(1'b0, 6, '0, "R6 repaired word");

    // R4 four adjacent columns 40..43 of row 2 -> words 8..11, bit 10 each
    strike(2, ROW_W'(4'hF) << 40);
    for (int a = 8; a < 12; a++) hostOp(1'b0, a, '0, "R4 burst corrected");
    waitFor(1'b0, 6, 2000);
    chk(corrCount == 6, "R4 burst gives four single errors", longint'(corrCount), 6);

    // R7 double error in word 14 (cols 2 and 14 of row 3)
    strike(3, (ROW_W'(1) << 2) | (ROW_W'(1) << 14));
    waitFor(1'b1, 1, 2000);
    tA = cyc;
    waitFor(1'b1, 2, 2000);
    tB = cyc;
    chk(uncorrCount == 2, "R7 counted on every visit", longint'(uncorrCount), 2);
    chk(tB - tA == 16 * 23, "R6 sweep period with wrap", longint'(tB - tA), 16 * 23);
    chk(corrCount == 6, "R7 double not corrected", longint'(corrCount), 6);
    @(negedge clk);
    chk(irqPulses == 8, "R9 one irq pulse per error found", longint'(irqPulses), 8);

    // R8 stalls behind scrub visits
    scrubGap = 8'd0;
    maxStall = 0;
    for (int i = 0; i < 40; i++) begin
      hostOp(1'b0, i % 8, '0, "R8 read under stall");
      @(negedge clk);
    end
    chk(maxStall <= 2, "R8 stall bound", longint'(maxStall), 2);
    chk(maxStall >= 1, "R8 scrub visit holds host", longint'(maxStall), 1);

    // R7 host rewrite clears the double error
    hostOp(1'b1, 14, 16'h1234, "R7");
    hostOp(1'b0, 14, '0, "R7 rewritten word");
    @(negedge clk);
    u0 = int'(uncorrCount);
    repeat (16 * 3 * 2 + 20) @(negedge clk);
    chk(int'(uncorrCount) == u0, "R7 rewrite clears error", longint'(uncorrCount), longint'(u0));

    // R10 saturation: doubles in word 0 (cols 0,4) and word 15 (cols 3,7)
    strike(0, (ROW_W'(1) << 0) | (ROW_W'(1) << 4));
    strike(3, (ROW_W'(1) << 3) | (ROW_W'(1) << 7));
    waitFor(1'b1, 255, 20000);
    chk(uncorrCount == 8'd255, "R10 reaches top", longint'(uncorrCount), 255);
    repeat (200) @(negedge clk);
    chk(uncorrCount == 8'd255, "R10 holds at top", longint'(uncorrCount), 255);

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R2 all reads returned", longint'(expQ.size()), 0);
    summary();
  end
endmodule